// File: doc/BRIEF.md
# Two-Wire Block-Protocol Configuration Slave

This block is a slave on a two-wire serial bus (SCL and SDA, with SDA handled as an open-drain pull-down plus a sampled input). It holds a small bank of 8-bit configuration registers and drives them to the rest of the chip as one flat vector. Both lines are brought into the system clock domain and filtered before any bus event is decoded. Start and stop conditions are recognised from SDA edges while SCL is high.

A host writes with the address byte 0xD2, followed by a command byte and a count byte. The slave acknowledges both and discards their contents. Data bytes then land in register 0, 1, 2 and upward in that order. A host reads with the address byte 0xD3. The slave first returns a count byte and then every register from 0 upward. A revision input is shown in the upper bits of register 0 on readback until software first writes that register.

Top module: `cfg_serial_slave`

## Requirements
- R1: Only the address bytes 0xD2 (write, 7-bit address 0x69 with R/W bit 0) and 0xD3 (read) are acknowledged. Any other address byte is left unacknowledged, the slave does not pull SDA low for the rest of that transfer, and no register changes.
- R2: In a write, the two bytes after the address (command and count) are acknowledged and ignored. The data bytes that follow are acknowledged and stored into register 0, 1, 2, … in order. Register k appears on cfg_o bits [8k+7:8k].
- R3: A stop after any complete data byte ends the write. Exactly the registers whose bytes were fully received are updated, and every other register keeps its value.
- R4: Data bytes beyond the last register are still acknowledged but change nothing.
- R5: In a read, the slave sends a count byte of value 8 (the register count) and then registers 0 to 7, each MSB first. SDA changes only while SCL is low.
- R6: When the host answers a read byte with NACK (SDA high in the acknowledge slot), the slave stops driving SDA for the rest of the transfer. A stop also releases SDA.
- R7: After reset, cfg_o holds the defaults: register 0 = 0x00, register 6 = 0x07, and all other registers = 0xFF.
- R8: Until register 0 has been written once, a read of register 0 returns rev_i in bits [7:4] and the default of register 0 in bits [3:0]. After the first write to register 0, a read returns the stored value.
- R9: A repeated start resets the transfer to the address phase. A new write after it again skips the command and count bytes and stores from register 0. A start also releases SDA.
- R10: The SDA pull-down changes only in the cycle after a filtered SCL falling edge or after a start or stop condition.
- R11: A pulse on SCL shorter than the filter length (4 system clocks) is not seen as a clock edge, so a write with such a glitch inside a bit still stores the intended data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_drive_o | output | 1 | 1 pulls SDA low; 0 releases it |
| rev_i | input | 4 | Revision value shown in register 0 readback until the first write |
| cfg_o | output | 64 | Register contents; register k on bits [8k+7:8k] |

## Verification
Writes are tried with full-length, short, zero-length and over-length data runs. Each one is followed by a bus readback and a comparison of cfg_o, which separates correct sequential loading from loads that overrun or leave registers stale. A read taken straight after reset tells the revision overlay apart from the stored register 0 value. A foreign address, a host NACK in the middle of a read, and a repeated start in the middle of a write each check that the slave lets go of SDA and restarts its byte pointer. A write with a short SCL glitch checks that the input filter keeps spurious edges out of the shift register.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_CMD  = 3'd2,
    PH_CNT  = 3'd3,
    PH_WR   = 3'd4,
    PH_RD   = 3'd5
  } phase_t;

  // 7-bit address compare on a received address byte
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] addr7);
    return rx[7:1] == addr7;
  endfunction

  // bit that leaves the slave in a given data slot (0 = MSB first)
  function automatic logic tx_bit(input logic [7:0] value, input logic [2:0] slot);
    return value[3'd7 - slot];
  endfunction

  // register 0 readback: revision overlay until first write
  function automatic logic [7:0] rev_overlay(input logic [7:0] dflt, input logic [7:0] rev_shifted,
                                             input logic [7:0] low_mask);
    return (dflt & low_mask) | rev_shifted;
  endfunction

endpackage

// File: rtl/cfgs_deglitch.sv
module cfgs_deglitch #(
  parameter int FILT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT + 1);

  logic          s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= '0;
      clean_o <= 1'b1;
    end else if (s2 == clean_o) begin
      run <= '0;
    end else if (run == CW'(FILT - 1)) begin
      run     <= '0;
      clean_o <= s2;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/cfgs_bus_events.sv
module cfgs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile #(
  parameter int          NREG     = 8,
  parameter int          REV_W    = 4,
  parameter logic [63:0] DEFAULTS = 64'hFF07_FFFF_FFFF_FF00
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(NREG+2)-1:0] wr_idx,
  input  logic [7:0]                wr_data,
  input  logic [REV_W-1:0]          rev_i,
  output logic [NREG*8-1:0]         cfg_o,
  output logic [NREG*8-1:0]         rb_o
);
  import cfgs_pkg::*;

  localparam logic [7:0] DEF0     = DEFAULTS[7:0];
  localparam logic [7:0] LOW_MASK = 8'hFF >> REV_W;

  logic       seen0;
  logic [7:0] rev_sh;

  assign rev_sh = 8'(rev_i) << (8 - REV_W);

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cfg_o[8*g +: 8] <= DEFAULTS[8*g +: 8];
        else if (wr_en && wr_idx == ($clog2(NREG+2))'(g))
          cfg_o[8*g +: 8] <= wr_data;
      end
      if (g == 0) begin : g_rb0
        assign rb_o[7:0] = seen0 ? cfg_o[7:0] : rev_overlay(DEF0, rev_sh, LOW_MASK);
      end else begin : g_rbn
        assign rb_o[8*g +: 8] = cfg_o[8*g +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen0 <= 1'b0;
    else if (wr_en && wr_idx == '0)
      seen0 <= 1'b1;
  end
endmodule

// File: rtl/cfgs_engine.sv
module cfgs_engine #(
  parameter int         NREG  = 8,
  parameter logic [6:0] ADDR7 = 7'h69
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sda_f,
  input  logic                      scl_rise,
  input  logic                      scl_fall,
  input  logic                      start_det,
  input  logic                      stop_det,
  input  logic [7:0]                tx_byte,
  output logic [$clog2(NREG+2)-1:0] rd_idx,
  output logic                      wr_en,
  output logic [$clog2(NREG+2)-1:0] wr_idx,
  output logic [7:0]                wr_data,
  output logic                      byte_done,
  output logic                      rd_mode,
  output logic                      sda_drive_o
);
  import cfgs_pkg::*;

  localparam int PW = $clog2(NREG + 2);
  localparam logic [PW-1:0] LAST_RD = PW'(NREG + 1);
  localparam logic [PW-1:0] WR_END  = PW'(NREG);

  phase_t        phase;
  logic [3:0]    slot;
  logic [6:0]    shreg;
  logic          ack_pend;
  logic [PW-1:0] wptr;
  logic [7:0]    rx;

  assign rx        = {shreg, sda_f};
  assign byte_done = (phase != PH_IDLE) && scl_rise && (slot == 4'd7);
  assign rd_mode   = (phase == PH_RD);
  assign wr_en     = byte_done && (phase == PH_WR) && (wptr < WR_END);
  assign wr_idx    = wptr;
  assign wr_data   = rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      slot        <= '0;
      shreg       <= '0;
      ack_pend    <= 1'b0;
      wptr        <= '0;
      rd_idx      <= '0;
      sda_drive_o <= 1'b0;
    end else if (start_det) begin
      phase       <= PH_ADDR;
      slot        <= '0;
      ack_pend    <= 1'b0;
      sda_drive_o <= 1'b0;
    end else if (stop_det) begin
      phase       <= PH_IDLE;
      ack_pend    <= 1'b0;
      sda_drive_o <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (slot == 4'd8) begin
          slot <= '0;
          if (ack_pend)
            ack_pend <= 1'b0;
          else if (phase == PH_RD) begin
            if (sda_f)
              phase <= PH_IDLE;
            else if (rd_idx != LAST_RD)
              rd_idx <= rd_idx + 1'b1;
          end
        end else begin
          shreg <= rx[6:0];
          slot  <= slot + 1'b1;
          if (slot == 4'd7) begin
            unique case (phase)
              PH_ADDR: begin
                if (addr_hit(rx, ADDR7)) begin
                  ack_pend <= 1'b1;
                  if (rx[0]) begin
                    phase  <= PH_RD;
                    rd_idx <= '0;
                  end else begin
                    phase <= PH_CMD;
                  end
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_CMD: begin
                ack_pend <= 1'b1;
                phase    <= PH_CNT;
              end
              PH_CNT: begin
                ack_pend <= 1'b1;
                phase    <= PH_WR;
                wptr     <= '0;
              end
              PH_WR: begin
                ack_pend <= 1'b1;
                if (wptr != WR_END) wptr <= wptr + 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
      if (scl_fall) begin
        if (slot == 4'd8)
          sda_drive_o <= ack_pend;
        else if (phase == PH_RD)
          sda_drive_o <= ~tx_bit(tx_byte, slot[2:0]);
        else
          sda_drive_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int          NREG     = 8,
  parameter int          REV_W    = 4,
  parameter int          FILT     = 4,
  parameter logic [6:0]  ADDR7    = 7'h69,
  parameter logic [63:0] DEFAULTS = 64'hFF07_FFFF_FFFF_FF00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_drive_o,
  input  logic [REV_W-1:0]   rev_i,
  output logic [NREG*8-1:0]  cfg_o
);
  localparam int PW = $clog2(NREG + 2);

  logic          scl_f, sda_f;
  logic          scl_rise_w, scl_fall_w, start_w, stop_w;
  logic          wr_en_w, byte_done_w, rd_mode_w;
  logic [PW-1:0] wr_idx_w, rd_idx_w;
  logic [7:0]    wr_data_w, tx_byte_w;
  logic [NREG*8-1:0] rb_w;

  cfgs_deglitch #(.FILT(FILT)) u_scl_flt (.clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f));
  cfgs_deglitch #(.FILT(FILT)) u_sda_flt (.clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f));

  cfgs_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_det(start_w), .stop_det(stop_w)
  );

  cfgs_engine #(.NREG(NREG), .ADDR7(ADDR7)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_f(sda_f),
    .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_det(start_w), .stop_det(stop_w),
    .tx_byte(tx_byte_w), .rd_idx(rd_idx_w),
    .wr_en(wr_en_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w),
    .byte_done(byte_done_w), .rd_mode(rd_mode_w),
    .sda_drive_o(sda_drive_o)
  );

  cfgs_regfile #(.NREG(NREG), .REV_W(REV_W), .DEFAULTS(DEFAULTS)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_idx(wr_idx_w),
    .wr_data(wr_data_w), .rev_i(rev_i), .cfg_o(cfg_o), .rb_o(rb_w)
  );

  // read stream: count byte, then registers 0..NREG-1, then idle-high filler
  always_comb begin
    tx_byte_w = 8'hFF;
    if (rd_idx_w == '0)
      tx_byte_w = 8'(NREG);
    else
      for (int i = 0; i < NREG; i++)
        if (rd_idx_w == PW'(i + 1)) tx_byte_w = rb_w[8*i +: 8];
  end
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker #(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall_w,
  input logic              start_w,
  input logic              stop_w,
  input logic              wr_en_w,
  input logic              byte_done_w,
  input logic              sda_drive_o,
  input logic [NREG*8-1:0] cfg_o
);
  // R10: pull-down only moves right after an SCL fall, start or stop
  assert_drive_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_o) |-> $past(scl_fall_w || start_w || stop_w));

  // R6: a stop always lets go of SDA
  assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !sda_drive_o);

  // R9: a start (or repeated start) lets go of SDA
  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !sda_drive_o);

  // R2: register outputs only change after an accepted data byte
  assert_cfg_only_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(wr_en_w));

  // R3: a store happens only on a completed byte
  assert_write_on_full_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_w |-> byte_done_w);
endmodule

bind cfg_serial_slave cfgs_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall_w(scl_fall_w), .start_w(start_w),
  .stop_w(stop_w), .wr_en_w(wr_en_w), .byte_done_w(byte_done_w),
  .sda_drive_o(sda_drive_o), .cfg_o(cfg_o)
);

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;
  localparam int Q = 12;  // quarter bit period in system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        glitch = 1'b0;
  logic        drv;
  logic [3:0]  rev = 4'hA;
  logic [63:0] cfg;
  wire         line = sda_m & ~drv;

  int checks = 0;
  int errors = 0;
  logic [7:0] mir [8];

  always #10 clk = ~clk;

  cfg_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .sda_drive_o(drv), .rev_i(rev), .cfg_o(cfg)
  );

  // {data byte count, 8 data bytes with byte 0 in the low bits}
  localparam logic [71:0] WVEC [5] = '{
    {8'd8,  64'h8877_6655_4433_2211},
    {8'd3,  64'h0000_0000_00C3_5AA5},
    {8'd10, 64'h0102_0408_1020_4080},
    {8'd1,  64'h0000_0000_0000_003C},
    {8'd0,  64'hDEAD_BEEF_DEAD_BEEF}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; wq(Q);
    scl = 1'b1;
    if (glitch) begin
      wq(Q / 2); scl = 1'b0; wq(2); scl = 1'b1; wq(Q / 2 - 2);
    end else wq(Q);
    seen = line; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(nack, s);
    sda_m = 1'b1;
  endtask

  task automatic read_all(input string req);
    logic a;
    logic [7:0] b;
    bus_start;
    put_byte(8'hD3, a);
    chk(req, {63'd0, a}, 64'd1);
    get_byte(1'b0, b);
    chk({req, " count byte"}, {56'd0, b}, 64'd8);
    for (int i = 0; i < 8; i++) begin
      get_byte(i == 7, b);
      chk($sformatf("%s byte %0d", req, i), {56'd0, b}, {56'd0, mir[i]});
    end
    bus_stop;
  endtask

  task automatic check_cfg(input string req);
    logic [63:0] e;
    for (int i = 0; i < 8; i++) e[8*i +: 8] = mir[i];
    chk(req, cfg, e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a, s;
    logic [7:0] b;
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R7: defaults
    mir = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h07, 8'hFF};
    check_cfg("R7 reset defaults");
    chk("R7 idle release", {63'd0, drv}, 64'd0);

    // R8: revision overlay before first write
    mir[0] = 8'hA0;
    read_all("R8 R5 readback after reset");
    mir[0] = 8'h00;

    // R1: foreign address is not acknowledged and changes nothing
    bus_start;
    put_byte(8'hA4, a);
    chk("R1 foreign address nack", {63'd0, a}, 64'd0);
    for (int i = 0; i < 4; i++) begin
      put_byte(8'h00, a);
      chk("R1 no drive after foreign address", {63'd0, a}, 64'd0);
    end
    bus_stop;
    check_cfg("R1 registers untouched");

    // table walk: R2 R3 R4 R5
    for (int t = 0; t < 5; t++) begin
      int n;
      n = int'(WVEC[t][71:64]);
      bus_start;
      put_byte(8'hD2, a);
      chk("R1 write address ack", {63'd0, a}, 64'd1);
      put_byte(8'h5F, a);
      chk("R2 command ack", {63'd0, a}, 64'd1);
      put_byte(8'h77, a);
      chk("R2 count ack", {63'd0, a}, 64'd1);
      for (int k = 0; k < n; k++) begin
        b = (k < 8) ? WVEC[t][8*k +: 8] : 8'hEE;
        put_byte(b, a);
        chk(k < 8 ? "R2 data ack" : "R4 overflow ack", {63'd0, a}, 64'd1);
        if (k < 8) mir[k] = b;
      end
      bus_stop;
      check_cfg($sformatf("R3 R4 cfg after vector %0d", t));
      read_all($sformatf("R5 readback vector %0d", t));
    end

    // R6: host NACK ends slave drive
    bus_start;
    put_byte(8'hD3, a);
    get_byte(1'b0, b);
    get_byte(1'b1, b);
    chk("R6 byte before nack", {56'd0, b}, {56'd0, mir[0]});
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      chk("R6 released after nack", {63'd0, s}, 64'd1);
    end
    bus_stop;

    // R9: repeated start restarts at register 0
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h00, a);
    put_byte(8'h11, a); put_byte(8'h22, a);
    mir[0] = 8'h11; mir[1] = 8'h22;
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h09, a); put_byte(8'h01, a);
    put_byte(8'h99, a);
    chk("R9 ack after repeated start", {63'd0, a}, 64'd1);
    mir[0] = 8'h99;
    bus_stop;
    check_cfg("R9 repeated start reloads byte 0");

    // R11: SCL glitch inside a bit does not disturb the write
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h00, a);
    glitch = 1'b1;
    put_byte(8'h6B, a);
    glitch = 1'b0;
    chk("R11 ack with glitch", {63'd0, a}, 64'd1);
    mir[0] = 8'h6B;
    bus_stop;
    check_cfg("R11 glitch filtered");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule